// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block decides when the core of a small 8-bit controller may be clocked and when its oscillator may run. It watches the opcodes the core fetches. A light-sleep opcode stops only the CPU clock, and the oscillator keeps running. The counter/timers and the interrupt inputs stay alive in light sleep. A deep-sleep opcode stops both the CPU clock and the oscillator. Either sleep opcode is honoured only when the opcode fetched just before it was a NOP. A sleep opcode that arrives without a NOP in front of it does nothing and sets a sticky error flag.

Light sleep ends when an interrupt request line is asserted and its enable bit is set. The core then carries on from where it stopped, so no restart vector is requested. Deep sleep ends in one of two ways. The first is a device reset. The second is the wake pin being low, which is sensed as a level after a synchroniser. A pin wake first restarts the oscillator. The CPU clock stays gated until a stabilisation count has run out. The block then requests a restart at the fixed resume address, and it signals that the port mode registers keep their present contents. A reset also requests the resume address, but it signals that the ports return to their power-on defaults.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `cpu_clk_en`=1, `osc_en`=1 and `seq_err`=0. While reset is asserted, `vec_req`=1 and `port_dflt`=1. `vec_req` falls after the first clock edge following release.
- R2: An opcode 0x7F accepted in the run state is honoured if the previous valid opcode was 0xFF, with idle cycles allowed between the two. From the next cycle, `cpu_clk_en`=0 and `osc_en`=1.
- R3: Light sleep ends on the edge at which `irq_req & irq_en` is nonzero. `cpu_clk_en` is 1 from the following cycle and `vec_req` stays 0. Masked requests and the wake pin have no effect in this state.
- R4: An opcode 0x6F that directly follows 0xFF (counting valid opcodes only) drives `cpu_clk_en`=0 and `osc_en`=0 from the next cycle.
- R5: In deep sleep, interrupt requests are ignored. A low level on `wake_pin_n` is seen through two synchroniser flops and then ends deep sleep.
- R6: On a pin wake, `osc_en` returns to 1 and `cpu_clk_en` stays 0 for exactly SETTLE_CYC cycles (64 by default). After that the state returns to run with a one-cycle `vec_req`, `vec_addr`=0x00C and `port_dflt`=0.
- R7: A reset during deep sleep restarts the block as in R1, with `port_dflt`=1.
- R8: A sleep opcode whose previous valid opcode was not 0xFF changes no clock enable. It sets `seq_err`, which stays set until reset.
- R9: Opcodes presented while the block is not in the run state are ignored.
- R10: If the synchronised pin is already low when deep sleep is entered, `osc_en` is low for exactly one cycle.
- R11: `core_stall` is 1 whenever `cpu_clk_en` is 0 and during the cycle `vec_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| op_valid | input | 1 | An opcode is fetched this cycle |
| op_code | input | 8 | Fetched opcode |
| irq_req | input | IRQ_N | Interrupt request lines |
| irq_en | input | IRQ_N | Per-line interrupt enable |
| wake_pin_n | input | 1 | Asynchronous wake pin, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_stall | output | 1 | Core must not advance |
| vec_req | output | 1 | Restart at `vec_addr` this cycle |
| vec_addr | output | VEC_W | Resume address |
| port_dflt | output | 1 | 1: port modes go to defaults, 0: they are kept |
| seq_err | output | 1 | Sticky: sleep opcode without a NOP in front of it |

## Verification
Every sleep entry and every light-sleep wake shows on the enables one cycle after the edge that captured the opcode or the interrupt. A pin level reaches the state register three edges after it is driven. It then holds the CPU clock off for SETTLE_CYC more cycles before the single `vec_req` cycle. The bench drives its inputs just after each rising edge. It advances a behavioural model, built from counters and a pin history queue, on that same edge, and it compares every output to the model on the falling edge. This lines up each result with the cycle in which it is due. Directed checks at chosen falling edges additionally pin down the one-cycle deep sleep of R10, the masked-interrupt and in-sleep opcode cases, and reset during deep sleep.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_LIGHT  = 2'd1,
        ST_DEEP   = 2'd2,
        ST_SETTLE = 2'd3
    } pwr_state_e;

    localparam logic [7:0] OPC_NOP   = 8'hFF;
    localparam logic [7:0] OPC_LIGHT = 8'h7F;
    localparam logic [7:0] OPC_DEEP  = 8'h6F;

    typedef struct packed {
        pwr_state_e st;
        logic       vec_req;
        logic       port_dflt;
    } ctl_regs_t;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic wake_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign wake_o = ~sync_q[STAGES-1];

    // a pin level takes STAGES edges to reach the output
    p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_q[STAGES-2]) == sync_q[STAGES-1]);
endmodule

// File: rtl/pwr_op_qual.sv
module pwr_op_qual
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_en,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    output logic       go_light,
    output logic       go_deep,
    output logic       seq_err
);
    typedef struct packed {
        logic nop_seen;
        logic err;
    } qual_t;

    qual_t r_d, r_q;
    logic  take, is_sleep;

    always_comb begin
        r_d      = r_q;
        take     = accept_en && op_valid;
        is_sleep = (op_code == OPC_LIGHT) || (op_code == OPC_DEEP);
        go_light = take && r_q.nop_seen && (op_code == OPC_LIGHT);
        go_deep  = take && r_q.nop_seen && (op_code == OPC_DEEP);
        if (take) begin
            r_d.nop_seen = (op_code == OPC_NOP);
            if (is_sleep && !r_q.nop_seen) r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign seq_err = r_q.err;

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);
    p_err_needs_sleep_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(op_valid && accept_en));
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        done = r_q.active && (r_q.cnt == LAST);
        if (start) begin
            r_d.active = 1'b1;
            r_d.cnt    = '0;
        end else if (done) begin
            r_d.active = 1'b0;
        end else if (r_q.active) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int               IRQ_N      = 4,
    parameter int               SETTLE_CYC = 64,
    parameter int               SYNC_STG   = 2,
    parameter int               VEC_W      = 12,
    parameter logic [VEC_W-1:0] RESUME_VEC = 12'h00C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [7:0]       op_code,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic             wake_pin_n,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             core_stall,
    output logic             vec_req,
    output logic [VEC_W-1:0] vec_addr,
    output logic             port_dflt,
    output logic             seq_err
);
    ctl_regs_t r_d, r_q;
    logic go_light, go_deep, pin_wake, settle_go, settle_done, irq_hit;

    pwr_wake_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_n_i(wake_pin_n), .wake_o(pin_wake));

    pwr_op_qual i_qual (
        .clk(clk), .rst_n(rst_n), .accept_en(r_q.st == ST_RUN),
        .op_valid(op_valid), .op_code(op_code),
        .go_light(go_light), .go_deep(go_deep), .seq_err(seq_err));

    pwr_settle_timer #(.LEN(SETTLE_CYC)) i_tmr (
        .clk(clk), .rst_n(rst_n), .start(settle_go), .done(settle_done));

    always_comb begin
        r_d         = r_q;
        r_d.vec_req = 1'b0;
        settle_go   = 1'b0;
        irq_hit     = |(irq_req & irq_en);
        unique case (r_q.st)
            ST_RUN: begin
                if (go_light)     r_d.st = ST_LIGHT;
                else if (go_deep) r_d.st = ST_DEEP;
            end
            ST_LIGHT: if (irq_hit) r_d.st = ST_RUN;
            ST_DEEP: begin
                if (pin_wake) begin
                    r_d.st    = ST_SETTLE;
                    settle_go = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    r_d.st        = ST_RUN;
                    r_d.vec_req   = 1'b1;
                    r_d.port_dflt = 1'b0;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RUN, vec_req: 1'b1, port_dflt: 1'b1};
        else        r_q <= r_d;
    end

    assign cpu_clk_en = (r_q.st == ST_RUN);
    assign osc_en     = (r_q.st != ST_DEEP);
    assign core_stall = (r_q.st != ST_RUN) || r_q.vec_req;
    assign vec_req    = r_q.vec_req;
    assign vec_addr   = RESUME_VEC;
    assign port_dflt  = r_q.port_dflt;

    p_osc_before_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);
    p_light_exit_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && $past(r_q.st) == ST_LIGHT) |-> $past(|(irq_req & irq_en)));
    p_deep_entry_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEEP && $past(r_q.st) == ST_RUN) |-> $past(op_valid && op_code == OPC_DEEP));
    p_pin_wake_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && $past(r_q.st) == ST_SETTLE) |-> vec_req && !port_dflt);
    p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);
    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> core_stall);
endmodule

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;
    localparam int SETTLE = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [3:0] irq_req = 4'h0, irq_en = 4'h0;
    logic       wake_pin_n = 1'b1;
    logic       cpu_clk_en, osc_en, core_stall, vec_req, port_dflt, seq_err;
    logic [11:0] vec_addr;

    int checks = 0, errors = 0, cyc = 0;

    // reference model state: 0 run, 1 light, 2 deep, 3 settle
    int  m_mode = 0, m_cnt = 0;
    bit  m_nop = 0, m_err = 0, m_vec = 1, m_dflt = 1;
    bit  pin_hist[$] = '{1'b1, 1'b1};

    pwr_sleep_ctrl i_pwr_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .irq_req(irq_req), .irq_en(irq_en), .wake_pin_n(wake_pin_n),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .core_stall(core_stall),
        .vec_req(vec_req), .vec_addr(vec_addr), .port_dflt(port_dflt),
        .seq_err(seq_err));

    always #4 clk = ~clk;

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_nop = 0; m_err = 0; m_vec = 1; m_dflt = 1;
            pin_hist = '{1'b1, 1'b1};
        end else begin
            bit woke;
            woke  = (pin_hist[1] == 1'b0);
            m_vec = 0;
            case (m_mode)
                0: if (op_valid) begin
                    if ((op_code == 8'h7F || op_code == 8'h6F)) begin
                        if (m_nop) m_mode = (op_code == 8'h7F) ? 1 : 2;
                        else       m_err  = 1;
                    end
                    m_nop = (op_code == 8'hFF);
                end
                1: if ((irq_req & irq_en) != 0) m_mode = 0;
                2: if (woke) begin m_mode = 3; m_cnt = 0; end
                default: begin
                    if (m_cnt == SETTLE - 1) begin m_mode = 0; m_vec = 1; m_dflt = 0; end
                    else m_cnt++;
                end
            endcase
            pin_hist.push_front(wake_pin_n);
            void'(pin_hist.pop_back());
        end
    end

    always @(negedge clk) begin
        string t;
        cyc++;
        t = (m_mode == 1) ? "R3" : (m_mode == 2) ? "R5" : (m_mode == 3) ? "R6" : "R2";
        check(t, "cpu_clk_en", 16'(cpu_clk_en), 16'(m_mode == 0));
        check("R4", "osc_en", 16'(osc_en), 16'(m_mode != 2));
        check("R11", "core_stall", 16'(core_stall), 16'((m_mode != 0) || m_vec));
        check("R6", "vec_req", 16'(vec_req), 16'(m_vec));
        check("R6", "vec_addr", 16'(vec_addr), 16'h00C);
        check("R7", "port_dflt", 16'(port_dflt), 16'(m_dflt));
        check("R8", "seq_err", 16'(seq_err), 16'(m_err));
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic op(logic [7:0] c);
        op_valid = 1'b1; op_code = c;
        @(posedge clk); #1;
        op_valid = 1'b0; op_code = 8'h00;
    endtask

    initial begin
        @(negedge clk);
        check("R1", "vec_req in reset", 16'(vec_req), 16'h1);
        check("R1", "port_dflt in reset", 16'(port_dflt), 16'h1);
        idle(3); rst_n = 1'b1; idle(2);
        @(negedge clk);
        check("R1", "cpu_clk_en after reset", 16'(cpu_clk_en), 16'h1);
        check("R1", "vec_req after reset", 16'(vec_req), 16'h0);

        // light sleep, masked irq and pin ignored, opcodes ignored
        op(8'hFF); op(8'h7F); idle(2);
        irq_req = 4'b0010; irq_en = 4'b0001; wake_pin_n = 1'b0; idle(4);
        @(negedge clk);
        check("R3", "masked irq keeps sleep", 16'(cpu_clk_en), 16'h0);
        @(posedge clk); #1;
        op(8'hFF); op(8'h6F); idle(1);
        @(negedge clk);
        check("R9", "op in light ignored", 16'(osc_en), 16'h1);
        @(posedge clk); #1;
        wake_pin_n = 1'b1; idle(3);
        irq_en = 4'b0010; idle(1);
        @(negedge clk);
        check("R3", "irq wake", 16'(cpu_clk_en), 16'h1);
        check("R3", "no vector on irq wake", 16'(vec_req), 16'h0);
        @(posedge clk); #1;
        irq_req = 4'h0; irq_en = 4'h0;

        // sleep opcode without NOP
        op(8'h7F); idle(1);
        @(negedge clk);
        check("R8", "seq_err set", 16'(seq_err), 16'h1);
        check("R8", "no sleep", 16'(cpu_clk_en), 16'h1);
        @(posedge clk); #1;

        // deep sleep with a gap after NOP, irq ignored, pin wake
        op(8'hFF); idle(2); op(8'h6F); idle(3);
        irq_req = 4'hF; irq_en = 4'hF; idle(3);
        @(negedge clk);
        check("R5", "irq ignored in deep", 16'(osc_en), 16'h0);
        @(posedge clk); #1;
        irq_req = 4'h0; irq_en = 4'h0;
        wake_pin_n = 1'b0; idle(SETTLE + 6);
        @(negedge clk);
        check("R6", "run after settle", 16'(cpu_clk_en), 16'h1);
        check("R6", "ports kept", 16'(port_dflt), 16'h0);
        @(posedge clk); #1;

        // pin already low at entry
        op(8'hFF); op(8'h6F);
        @(negedge clk);
        check("R10", "deep one cycle", 16'(osc_en), 16'h0);
        @(negedge clk);
        check("R10", "osc back", 16'(osc_en), 16'h1);
        @(posedge clk); #1;
        wake_pin_n = 1'b1; idle(SETTLE + 4);

        // reset during deep sleep
        op(8'hFF); op(8'h6F); idle(5);
        rst_n = 1'b0; idle(2);
        @(negedge clk);
        check("R7", "vec_req on reset", 16'(vec_req), 16'h1);
        check("R7", "defaults on reset", 16'(port_dflt), 16'h1);
        @(posedge clk); #1;
        rst_n = 1'b1; idle(3);
        @(negedge clk);
        check("R1", "run after reset", 16'(cpu_clk_en), 16'h1);
        check("R1", "err cleared", 16'(seq_err), 16'h0);
        @(posedge clk); #1;

        // NOP interrupted by another opcode, then double NOP
        op(8'hFF); op(8'h01); op(8'h6F); idle(1);
        @(negedge clk);
        check("R8", "broken pair err", 16'(seq_err), 16'h1);
        check("R8", "broken pair no sleep", 16'(osc_en), 16'h1);
        @(posedge clk); #1;
        op(8'hFF); op(8'hFF); op(8'h7F);
        @(negedge clk);
        check("R2", "light after double NOP", 16'(cpu_clk_en), 16'h0);
        check("R2", "osc on in light", 16'(osc_en), 16'h1);
        @(posedge clk); #1;
        irq_req = 4'b1000; irq_en = 4'b1000; idle(3);
        irq_req = 4'h0; irq_en = 4'h0; idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule